// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block collects sixteen external interrupt request lines from board logic and presents one combined request to a host processor. Each line that is high at a clock edge while its enable bit is set leaves a pending bit behind. That pending bit stays set until software rewrites the pending register. The host request is the OR over all bits that are both pending and enabled. A raw-level register shows the level of every line as sampled at the most recent edge, whether or not the line is enabled.

The block also holds two card-socket registers. Software controls the power and reset field, which is the low five bits of each register. Bit 10 is a ready flag that always reads 1. Bit 5 is an active-low card-detect flag. Source line 9 drives the card-detect flag of socket 0, and source line 13 drives the flag of socket 1.

Register access is a plain synchronous bus with an 8-bit byte offset, a write strobe, 32-bit write data and combinational read data. The offsets are:

| Register | Offset |
|---|---|
| enable | 0xC0 |
| raw level | 0xC8 |
| pending | 0xD0 |
| socket 0 | 0xE0 |
| socket 1 | 0xE4 |

Top module: `sticky_irq_hub`

## Requirements
- R1: After reset, the enable, pending and raw-level registers read 0, `irq_host` is 0, and both socket registers read 0x00000420 (ready bit 10 = 1, card-detect bit 5 = 1, control bits 4:0 = 0).
- R2: A write to offset 0xC0 stores `wdata & 0x000FEEFF` into the enable register. Every bit outside that mask reads back as 0.
- R3: A write to offset 0xD0 replaces the whole pending register with `wdata & 0x000FEEFF`, so software can both set and clear pending bits.
- R4: A source line that is high at a clock edge while its enable bit is set makes its pending bit read 1 after that edge. The bit stays 1 after the line goes low.
- R5: A source line whose enable bit is 0 at the edge leaves its pending bit unchanged. This includes lines 8 and 12, whose enable bits can never be set.
- R6: `irq_host` is 1 exactly when some bit is set in both the pending register and the enable register.
- R7: When a pending-register write and a source assertion fall in the same cycle, the written value wins.
- R8: Offset 0xC8 reads the level of every source line as sampled at the last clock edge, placed in bits 15:0, whether or not the line is enabled. Writes to 0xC8 are ignored.
- R9: A write to a socket register (0xE0, 0xE4) changes only bits 4:0. Bit 10 reads 1 at all times, and all other bits stay as they were.
- R10: Bit 5 of socket 0 reads the inverse of source line 9 as sampled at the last edge. Bit 5 of socket 1 reads the inverse of source line 13 in the same way.
- R11: Reads of any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_src | input | 16 | Interrupt source levels, synchronous to `clk` |
| irq_host | output | 1 | Combined interrupt request to the host |

## Verification
Every stored value changes at one clock edge: a write, a latched source line, a raw level or a card-detect flag. Read data and `irq_host` are combinational from registers, so each result is due one edge after the cycle that caused it. The bench drives each cycle at the falling edge and predicts the state right after the next rising edge. It pushes that prediction into a queue, and a monitor compares it one time unit after the rising edge. Same-cycle races, such as a write and an assertion, or an enable change and an assertion, are predicted using the register values from before that edge.

// File: rtl/sticky_irq_pkg.sv
package sticky_irq_pkg;
    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] OFS_EN    = 8'hC0;
    localparam logic [AW-1:0] OFS_LVL   = 8'hC8;
    localparam logic [AW-1:0] OFS_PEND  = 8'hD0;
    localparam logic [AW-1:0] OFS_SOCK0 = 8'hE0;
    localparam logic [AW-1:0] OFS_SOCK1 = 8'hE4;

    localparam logic [DW-1:0] SRC_MASK = 32'h000F_EEFF;

    localparam int SOCK_CTL_W   = 5;
    localparam int SOCK_CD_BIT  = 5;
    localparam int SOCK_RDY_BIT = 10;
    localparam int NUM_SOCK     = 2;
endpackage

// File: rtl/sticky_irq_regs.sv
module sticky_irq_regs
    import sticky_irq_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_we,
    input  logic          pend_we,
    input  logic [DW-1:0] wdata,
    input  logic [NUM_SRC-1:0] src,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] pend_q,
    output logic [DW-1:0] lvl_q
);
    logic [DW-1:0] src_ext;
    logic [DW-1:0] pend_d;

    assign src_ext = DW'(src);

    // Bus write has priority over a same-cycle latch.
    always_comb begin
        if (pend_we) pend_d = wdata & SRC_MASK;
        else         pend_d = pend_q | (src_ext & en_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            lvl_q  <= '0;
        end else begin
            if (en_we) en_q <= wdata & SRC_MASK;
            pend_q <= pend_d;
            lvl_q  <= src_ext;
        end
    end
endmodule

// File: rtl/sticky_irq_socket.sv
module sticky_irq_socket
    import sticky_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SOCK_CTL_W-1:0] ctl_in,
    input  logic          det_level,
    output logic [DW-1:0] word,
    output logic          cd_n
);
    logic [SOCK_CTL_W-1:0] ctl_q;

    always_ff @(posedge clk) begin
        if (!rst_n)  ctl_q <= '0;
        else if (we) ctl_q <= ctl_in;
    end

    assign cd_n = ~det_level;

    always_comb begin
        word = '0;
        word[SOCK_CTL_W-1:0] = ctl_q;
        word[SOCK_CD_BIT]    = cd_n;
        word[SOCK_RDY_BIT]   = 1'b1;
    end
endmodule

// File: rtl/sticky_irq_decode.sv
module sticky_irq_decode
    import sticky_irq_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] en_q,
    input  logic [DW-1:0] lvl_q,
    input  logic [DW-1:0] pend_q,
    input  logic [DW-1:0] sock0,
    input  logic [DW-1:0] sock1,
    output logic          en_we,
    output logic          pend_we,
    output logic [NUM_SOCK-1:0] sock_we,
    output logic [DW-1:0] rdata
);
    assign en_we      = wr && (addr == OFS_EN);
    assign pend_we    = wr && (addr == OFS_PEND);
    assign sock_we[0] = wr && (addr == OFS_SOCK0);
    assign sock_we[1] = wr && (addr == OFS_SOCK1);

    always_comb begin
        unique case (addr)
            OFS_EN:    rdata = en_q;
            OFS_LVL:   rdata = lvl_q;
            OFS_PEND:  rdata = pend_q;
            OFS_SOCK0: rdata = sock0;
            OFS_SOCK1: rdata = sock1;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/sticky_irq_hub.sv
module sticky_irq_hub
    import sticky_irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int CD0_SRC = 9,
    parameter int CD1_SRC = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [15:0]   irq_src,
    output logic          irq_host
);
    logic [DW-1:0] en_q, pend_q, lvl_q;
    logic          en_we, pend_we;
    logic [NUM_SOCK-1:0] sock_we;
    logic [NUM_SOCK-1:0] cd_n;
    logic [DW-1:0] sock_word [NUM_SOCK];

    sticky_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (en_we),
        .pend_we (pend_we),
        .wdata   (bus_wdata),
        .src     (irq_src),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .lvl_q   (lvl_q)
    );

    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
        localparam int SRC_IDX = (g == 0) ? CD0_SRC : CD1_SRC;
        sticky_irq_socket u_sock (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (sock_we[g]),
            .ctl_in    (bus_wdata[SOCK_CTL_W-1:0]),
            .det_level (lvl_q[SRC_IDX]),
            .word      (sock_word[g]),
            .cd_n      (cd_n[g])
        );
    end

    sticky_irq_decode u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .en_q    (en_q),
        .lvl_q   (lvl_q),
        .pend_q  (pend_q),
        .sock0   (sock_word[0]),
        .sock1   (sock_word[1]),
        .en_we   (en_we),
        .pend_we (pend_we),
        .sock_we (sock_we),
        .rdata   (bus_rdata)
    );

    assign irq_host = |(pend_q & en_q);
endmodule

// File: rtl/sticky_irq_hub_chk.sv
module sticky_irq_hub_chk
    import sticky_irq_pkg::*;
#(
    parameter int CD0_SRC = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [7:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [15:0]   irq_src,
    input logic [31:0]   pend,
    input logic [31:0]   en,
    input logic          cd0_n
);
    logic          pend_wr;
    logic [31:0]   src_ext;
    assign pend_wr = bus_wr && (bus_addr == OFS_PEND);
    assign src_ext = 32'(irq_src);

    a_r2_holes: assert property (@(posedge clk) disable iff (!rst_n)
        ((en | pend) & ~SRC_MASK) == '0);

    a_r3_replace: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pend_wr)) |-> pend == ($past(bus_wdata) & SRC_MASK));

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pend_wr)) |-> (pend & $past(pend)) == $past(pend));

    a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pend_wr)) |->
            (pend & $past(src_ext & en)) == $past(src_ext & en));

    a_r10_cd: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cd0_n == !$past(irq_src[CD0_SRC]));
endmodule

bind sticky_irq_hub sticky_irq_hub_chk #(.CD0_SRC(CD0_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_src   (irq_src),
    .pend      (pend_q),
    .en        (en_q),
    .cd0_n     (cd_n[0])
);

// File: tb/sim_sticky_irq_hub.sv
module sim_sticky_irq_hub;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h000F_EEFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_src = '0;
    logic        irq_host;

    sticky_irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_host(irq_host)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    // reference state, following the requirements
    logic [31:0] m_en = '0, m_pend = '0, m_lvl = '0;
    logic [4:0]  m_s0 = '0, m_s1 = '0;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'hC0: return m_en;
            8'hC8: return m_lvl;
            8'hD0: return m_pend;
            8'hE0: return 32'h400 | (m_lvl[9]  ? 32'h0 : 32'h20) | 32'(m_s0);
            8'hE4: return 32'h400 | (m_lvl[13] ? 32'h0 : 32'h20) | 32'(m_s1);
            default: return 32'h0;
        endcase
    endfunction

    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] s, input string tag);
        logic [31:0] old_en;
        exp_t e;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; irq_src = s;
        old_en = m_en;
        if (wr && a == 8'hC0) m_en = d & MASK;
        if (wr && a == 8'hD0) m_pend = d & MASK;
        else                  m_pend = m_pend | (32'(s) & old_en);
        if (wr && a == 8'hE0) m_s0 = d[4:0];
        if (wr && a == 8'hE4) m_s1 = d[4:0];
        m_lvl = 32'(s);
        e.rd = m_read(a);
        e.irq = |(m_pend & m_en);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] s, input string tag);
        cyc(1'b0, a, 32'h0, s, tag);
    endtask

    // monitor: compares one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (bus_rdata !== e.rd || irq_host !== e.irq) begin
                n_errors++;
                $display("FAIL %s rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, bus_rdata, irq_host, e.rd, e.irq);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'hE0, 16'h0, "R1");
        rd(8'hE4, 16'h0, "R1");
        rd(8'hC0, 16'h0, "R1");
        rd(8'hD0, 16'h0, "R1");
        rd(8'hC8, 16'h0, "R1");

        // R2 enable mask
        cyc(1'b1, 8'hC0, 32'hFFFF_FFFF, 16'h0, "R2");
        cyc(1'b1, 8'hC0, 32'h1234_5678, 16'h0, "R2");
        rd(8'hC0, 16'h0, "R2");

        // R3 pending replace, set then clear
        cyc(1'b1, 8'hD0, 32'hFFFF_FFFF, 16'h0, "R3");
        cyc(1'b1, 8'hD0, 32'h0000_0100, 16'h0, "R3");
        cyc(1'b1, 8'hD0, 32'h0, 16'h0, "R3");

        // R4 latch and stickiness, R6 output
        cyc(1'b1, 8'hC0, 32'h0000_FFFF, 16'h0, "R4");
        rd(8'hD0, 16'h0001, "R4");
        rd(8'hD0, 16'h0000, "R4");
        rd(8'hD0, 16'h8002, "R6");
        rd(8'hD0, 16'h0000, "R4");

        // R5 disabled lines, including the holes at 8 and 12
        cyc(1'b1, 8'hD0, 32'h0, 16'h0, "R5");
        rd(8'hD0, 16'h1100, "R5");
        cyc(1'b1, 8'hC0, 32'h0, 16'h0, "R5");
        rd(8'hD0, 16'h00F0, "R5");
        rd(8'hD0, 16'h0000, "R5");

        // R6 pending without enable keeps output low, enabling raises it
        cyc(1'b1, 8'hD0, 32'h0008_0010, 16'h0, "R6");
        cyc(1'b1, 8'hC0, 32'h0000_0010, 16'h0, "R6");
        cyc(1'b1, 8'hC0, 32'h0000_0001, 16'h0, "R6");

        // R7 write beats same-cycle assertion
        cyc(1'b1, 8'hC0, 32'h0000_FFFF, 16'h0, "R7");
        cyc(1'b1, 8'hD0, 32'h0, 16'h0004, "R7");
        cyc(1'b1, 8'hD0, 32'h0000_0001, 16'h0040, "R7");
        rd(8'hD0, 16'h0, "R7");

        // R8 raw level independent of enable
        cyc(1'b1, 8'hC0, 32'h0, 16'h0, "R8");
        rd(8'hC8, 16'hA5A5, "R8");
        cyc(1'b1, 8'hC8, 32'hFFFF_FFFF, 16'h5A5A, "R8");
        rd(8'hC8, 16'h0000, "R8");

        // R9 socket control field
        cyc(1'b1, 8'hE0, 32'hFFFF_FFFF, 16'h0, "R9");
        cyc(1'b1, 8'hE4, 32'hFFFF_FC12, 16'h0, "R9");
        rd(8'hE0, 16'h0, "R9");

        // R10 card detect
        rd(8'hE0, 16'h0200, "R10");
        rd(8'hE4, 16'h0200, "R10");
        rd(8'hE4, 16'h2000, "R10");
        rd(8'hE0, 16'h2000, "R10");
        rd(8'hE4, 16'h0000, "R10");

        // R11 unmapped offsets
        cyc(1'b1, 8'hC4, 32'hFFFF_FFFF, 16'h0, "R11");
        rd(8'h00, 16'h0, "R11");
        rd(8'hC0, 16'h0, "R11");
        rd(8'hD0, 16'h0, "R11");
        cyc(1'b1, 8'hE8, 32'hFFFF_FFFF, 16'h0, "R11");
        rd(8'hE0, 16'h0, "R11");

        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule